// File: doc/BRIEF.md
# Four-channel prescaled pulse-width modulator

The block generates four independent pulse-width modulated outputs from one input clock. Each channel counts its period with two cascaded 16-bit dividers. A prescaler divides the input clock into ticks, and a period divider counts those ticks. The output is high for a programmable number of ticks at the start of every period and low for the rest. A software-visible register port with single-cycle writes and registered reads carries the configuration.

Configuration is written into staging registers. The prescaler, the period divider and the high-duration count move into the running configuration together, and only when a commit is requested. A running channel applies the commit at its next period boundary, so no period ever mixes old and new settings. A disabled channel drives its output low and applies a commit at once.

Top module: `pwm_ctrl`

## Requirements
- R1: Channel i (0..3) has two 32-bit registers. The first is at byte address 8*i and holds the period divider in bits 15:0 and the high-duration count in bits 31:16. The second is at 8*i+4 and holds the prescaler in bits 15:0, the commit bit in bit 30 and the enable bit in bit 31. Address bits 1:0 are ignored. A read with rd_en returns the staged values on rdata one clock after the read cycle.
- R2: The commit bit is self-clearing and always reads back as 0.
- R3: Writing the registers without the commit bit leaves the output waveform unchanged, including a staged prescaler change.
- R4: While enabled, the output period is (prescaler+1)*(period divider+1) input clock cycles.
- R5: The output is high for high-duration*(prescaler+1) cycles at the start of each period and low for the rest of it.
- R6: The running enable follows the written enable bit one clock after the write. Two clocks after a write that clears it, the output is low and stays low. A commit made while the channel is disabled applies immediately.
- R7: A commit to a running channel is acted on one clock after the write and takes effect at the next period boundary. All three values change together.
- R8: A high-duration greater than the period divider keeps the output constantly high. A high-duration of 0 keeps the output constantly low.
- R9: Reset (synchronous, active high) clears every staged and running value, disables all channels and drives all outputs and rdata to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Byte address of the register |
| wr_en | input | 1 | Write strobe for one cycle |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe for one cycle |
| rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
The bench runs the channels with several settings: an ordinary ratio, a prescaler of 0, a duration above the period, and a duration of 0. These separate the prescaler term from the divider term in the period and high-time formulas, and expose clamping errors at both extremes. Staged writes without a commit, commits issued mid-period and commits issued while disabled are compared against a behavioural model on every clock. Any early, late or partial transfer shows up there. Register read-back covers field placement and the self-clearing commit bit.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Word layout shared by the register file and its decoder
  localparam int REG_W   = 32;
  localparam int HI_LSB  = 16;
  localparam int UPD_BIT = 30;
  localparam int EN_BIT  = 31;
  localparam int SEL_BIT = 2;
  localparam int CH_LSB  = 3;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         wr_en,
  input  logic [REG_W-1:0]             wdata,
  input  logic                         rd_en,
  output logic [REG_W-1:0]             rdata,
  output logic [NUM_CH-1:0][CNT_W-1:0] stg_pre,
  output logic [NUM_CH-1:0][CNT_W-1:0] stg_div,
  output logic [NUM_CH-1:0][CNT_W-1:0] stg_hi,
  output logic [NUM_CH-1:0]            stg_en,
  output logic [NUM_CH-1:0]            upd
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [CH_W-1:0]  ch;
  logic             sel;
  logic [REG_W-1:0] rword;
  logic             unused_bits;

  assign ch          = addr[CH_LSB +: CH_W];
  assign sel         = addr[SEL_BIT];
  assign unused_bits = ^{addr[1:0], wdata};

  always_comb begin
    rword = '0;
    if (sel) begin
      rword[CNT_W-1:0] = stg_pre[ch];
      rword[EN_BIT]    = stg_en[ch];
    end else begin
      rword[CNT_W-1:0]         = stg_div[ch];
      rword[HI_LSB +: CNT_W]   = stg_hi[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_pre <= '0;
      stg_div <= '0;
      stg_hi  <= '0;
      stg_en  <= '0;
      upd     <= '0;
      rdata   <= '0;
    end else begin
      upd <= '0;
      if (wr_en) begin
        if (sel) begin
          stg_pre[ch] <= wdata[CNT_W-1:0];
          stg_en[ch]  <= wdata[EN_BIT];
          upd[ch]     <= wdata[UPD_BIT];
        end else begin
          stg_div[ch] <= wdata[CNT_W-1:0];
          stg_hi[ch]  <= wdata[HI_LSB +: CNT_W];
        end
      end
      if (rd_en) rdata <= rword;
    end
  end

  // R7: a single write can raise at most one channel's commit request
  p_single_commit_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(upd));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_s,
  input  logic             upd,
  input  logic [CNT_W-1:0] stg_pre,
  input  logic [CNT_W-1:0] stg_div,
  input  logic [CNT_W-1:0] stg_hi,
  output logic             pwm_out
);
  logic             en_a, pend;
  logic [CNT_W-1:0] pcnt, dcnt, pre_a, div_a, hi_a;
  logic             tick, wrap, load;

  assign tick = (pcnt == pre_a);
  assign wrap = tick && (dcnt == div_a);
  assign load = (upd || pend) && (!en_a || wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_a    <= 1'b0;
      pend    <= 1'b0;
      pcnt    <= '0;
      dcnt    <= '0;
      pre_a   <= '0;
      div_a   <= '0;
      hi_a    <= '0;
      pwm_out <= 1'b0;
    end else begin
      en_a    <= en_s;
      pwm_out <= en_a && (dcnt < hi_a);
      if (load) begin
        pre_a <= stg_pre;
        div_a <= stg_div;
        hi_a  <= stg_hi;
      end
      if (!en_a) begin
        pcnt <= '0;
        dcnt <= '0;
        pend <= 1'b0;
      end else begin
        if (tick) begin
          pcnt <= '0;
          dcnt <= wrap ? '0 : dcnt + 1'b1;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
        pend <= wrap ? 1'b0 : (pend | upd);
      end
    end
  end

  // R4: both counters stay inside the running limits
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    en_a |-> (pcnt <= pre_a) && (dcnt <= div_a));
  // R7: running settings only move at a period boundary
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (en_a && !wrap) |=> ($stable(pre_a) && $stable(div_a) && $stable(hi_a)));
  // R6: a disabled channel drives low
  p_off_low_r6: assert property (@(posedge clk) disable iff (rst)
    !en_a |=> !pwm_out);
  // R8: duration beyond the period holds the output high
  p_full_high_r8: assert property (@(posedge clk) disable iff (rst)
    (en_a && (hi_a > div_a)) |=> pwm_out);
  // R8: zero duration holds the output low
  p_zero_low_r8: assert property (@(posedge clk) disable iff (rst)
    (hi_a == '0) |=> !pwm_out);
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = $clog2(NUM_CH) + CH_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0][CNT_W-1:0] stg_pre, stg_div, stg_hi;
  logic [NUM_CH-1:0]            stg_en, upd;

  pwm_regfile #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .stg_pre(stg_pre), .stg_div(stg_div),
    .stg_hi(stg_hi), .stg_en(stg_en), .upd(upd)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .en_s(stg_en[g]), .upd(upd[g]),
      .stg_pre(stg_pre[g]), .stg_div(stg_div[g]), .stg_hi(stg_hi[g]),
      .pwm_out(pwm_out[g])
    );
  end

  // R9: outputs are quiet right after reset
  p_reset_quiet_r9: assert property (@(posedge clk)
    $past(rst) |-> (pwm_out == '0) && (rdata == '0));
endmodule

// File: tb/pwm_ctrl_bench.sv
module pwm_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  pwm_ctrl u_pwm_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .pwm_out(pwm_out)
  );

  // Behavioural reference of the requirements
  int s_pre[4], s_div[4], s_hi[4], a_pre[4], a_div[4], a_hi[4];
  int pc[4], dc[4];
  bit s_en[4], r_en[4], pend[4], upd_d[4];
  logic [3:0]  m_out;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        s_pre[c] = 0; s_div[c] = 0; s_hi[c] = 0; a_pre[c] = 0; a_div[c] = 0;
        a_hi[c] = 0; pc[c] = 0; dc[c] = 0; s_en[c] = 0; r_en[c] = 0;
        pend[c] = 0; upd_d[c] = 0;
      end
      m_out = '0; m_rdata = '0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        bit wrap, apply;
        m_out[c] = r_en[c] && (dc[c] < a_hi[c]);
        wrap = (pc[c] == a_pre[c]) && (dc[c] == a_div[c]);
        apply = (upd_d[c] || pend[c]) && (!r_en[c] || wrap);
        if (!r_en[c]) begin
          pc[c] = 0; dc[c] = 0; pend[c] = 0;
        end else begin
          if (pc[c] == a_pre[c]) begin
            pc[c] = 0; dc[c] = wrap ? 0 : dc[c] + 1;
          end else pc[c] = pc[c] + 1;
          pend[c] = wrap ? 0 : (pend[c] | upd_d[c]);
        end
        if (apply) begin a_pre[c] = s_pre[c]; a_div[c] = s_div[c]; a_hi[c] = s_hi[c]; end
        r_en[c] = s_en[c];
        upd_d[c] = 0;
      end
      if (rd_en) begin
        int c;
        c = int'(addr[4:3]);
        if (addr[2]) m_rdata = {s_en[c], 15'd0, 16'(s_pre[c])};
        else m_rdata = {16'(s_hi[c]), 16'(s_div[c])};
      end
      if (wr_en) begin
        int c;
        c = int'(addr[4:3]);
        if (addr[2]) begin
          s_pre[c] = int'(wdata[15:0]); s_en[c] = wdata[31]; upd_d[c] = wdata[30];
        end else begin
          s_div[c] = int'(wdata[15:0]); s_hi[c] = int'(wdata[31:16]);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison (R3, R6, R7 timing; R1 read data)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(pwm_out == m_out, "R7 output vs model", pwm_out, m_out);
      chk(rdata == m_rdata, "R1 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 5'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = 5'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic wait_rise(input int c);
    int g = 0;
    while (pwm_out[c] !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
    while (pwm_out[c] !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic measure(input int c, input int exp_hi, input int exp_per, input string tag);
    int hi = 0, per = 0;
    wait_rise(c);
    wait_rise(c);
    while (pwm_out[c] === 1'b1 && per < 5000) begin @(negedge clk); hi++; per++; end
    while (pwm_out[c] === 1'b0 && per < 5000) begin @(negedge clk); per++; end
    chk(hi == exp_hi, {tag, " high time"}, hi, exp_hi);
    chk(per == exp_per, {tag, " period"}, per, exp_per);
  endtask

  task automatic hold_level(input int c, input logic lvl, input string tag);
    int bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pwm_out[c] !== lvl) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp_on = 1;
    // R9: reset state
    chk(pwm_out == 4'b0, "R9 outputs low after reset", pwm_out, 0);
    rd(5'h0C, 32'h0, "R9 staged value cleared");

    // R1/R2: layout and read-back
    wr(5'h00, 32'h0003_0009);
    wr(5'h04, 32'hC000_0001);
    rd(5'h00, 32'h0003_0009, "R1 first register read");
    rd(5'h07, 32'h8000_0001, "R2 commit bit reads 0, R1 low bits ignored");

    // R4/R5: pre=1 div=9 hi=3 -> 6 high of 20
    measure(0, 6, 20, "R4 R5 ch0");

    // R3: staged changes without commit
    wr(5'h00, 32'h0002_0004);
    wr(5'h04, 32'h8000_0000);
    measure(0, 6, 20, "R3 ch0 unchanged");

    // R7: commit mid-run, pre=0 div=4 hi=2 -> 2 of 5
    repeat (3) @(negedge clk);
    wr(5'h04, 32'hC000_0000);
    measure(0, 2, 5, "R7 ch0 after commit");

    // R8: full and zero duration
    wr(5'h08, 32'h0007_0003);
    wr(5'h0C, 32'hC000_0002);
    wr(5'h10, 32'h0000_0003);
    wr(5'h14, 32'hC000_0000);
    repeat (3) @(negedge clk);
    hold_level(1, 1'b1, "R8 ch1 constantly high");
    hold_level(2, 1'b0, "R8 ch2 constantly low");

    // R6: disable, then commit while disabled
    wr(5'h04, 32'h0000_0000);
    @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R6 output low after disable", pwm_out[0], 0);
    hold_level(0, 1'b0, "R6 stays low while disabled");
    wr(5'h00, 32'h0001_0002);
    wr(5'h04, 32'h4000_0003);
    wr(5'h04, 32'h8000_0003);
    measure(0, 4, 12, "R6 commit while disabled applied");
    chk(pwm_out[3] == 1'b0, "R9 untouched channel low", pwm_out[3], 0);

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule